// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Priming and Self-Refresh

This block keeps an asynchronous DRAM's contents alive and brings the device up after power-on. Out of reset it holds the strobes idle for a programmable pause. It then drives a fixed number of priming refresh cycles on its own before it raises `ready`. From that point on, an interval timer adds one owed refresh per period. The block asks the access controller for the strobes through a request/grant handshake. Once the request is granted, it drives one CAS-before-RAS cycle. In that cycle CAS falls first, RAS follows, the write strobe stays high, and address and data are left alone.

The handshake follows valid/ready rules. `ref_req` acts as valid and `ref_gnt` as ready. A request is accepted in a cycle where both are high. The request stays high while refreshes are owed, however long the grant is withheld. While the grant is withheld the block owes more refreshes but does not touch the strobes. The owed count saturates at a limit, and `ref_urgent` is raised while the count is at that limit. The controller is expected to close its open page at the next column boundary and grant. After acceptance, `bus_own` stays high for the whole cycle. The request drops and the strobes belong to the block until `bus_own` falls.

Holding `sr_req` asks for self-refresh. Once that request is accepted, the block runs the following sequence without giving up the strobes:
- one normal refresh;
- a CBR cycle whose RAS-low phase lasts at least the self-refresh minimum and continues until `sr_req` drops;
- the longer self-refresh precharge;
- one more normal refresh.

The interval timer is frozen for the whole sequence. All times are clock-cycle parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset `ready` and `ref_req` are 0 and `ras_n`/`cas_n` are 1; `ready` rises exactly PAUSE_CYC + PRIME_CNT*(T_CSR+T_RAS+T_RP+1) clock edges after reset is released.
- R2: Before `ready` rises the block issues exactly PRIME_CNT refresh cycles without asserting `ref_req`.
- R3: Every refresh cycle lowers `cas_n` exactly T_CSR cycles before `ras_n` falls, holds `we_n` at 1 throughout, and raises `cas_n` in the same cycle as `ras_n`; a normal cycle keeps `ras_n` low for exactly T_RAS cycles.
- R4: Back-to-back normal refresh cycles leave `cas_n` high for T_RP+1 cycles between them.
- R5: While `ready`, each INTERVAL_CYC cycles of normal operation add one owed refresh; the first `ref_req` rises INTERVAL_CYC cycles after `ready`, and with the grant held high each interval yields exactly one refresh.
- R6: Without `ref_gnt` the strobes stay high, `bus_own` stays 0 and `ref_req` stays asserted; after acceptance `bus_own` is 1 for the whole cycle and no strobe is low while `bus_own` is 0.
- R7: The owed count saturates at OWED_MAX; `ref_urgent` rises OWED_MAX*INTERVAL_CYC cycles after `ready` when no grant is given; a later continuous grant delivers exactly OWED_MAX refreshes and clears `ref_urgent`.
- R8: An accepted `sr_req` first yields one normal refresh, then a CBR cycle whose RAS-low phase lasts max(SR_MIN_CYC, cycles until `sr_req` is seen low).
- R9: After self-refresh RAS rises, `cas_n` stays high for T_RPS+1 cycles, one normal refresh follows, then `bus_own` falls; no refresh is owed for the time spent in self-refresh.
- R10: `sr_active` is 1 during the held self-refresh phase and 0 once the strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller grants the strobes (ready side of the handshake) |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ready | output | 1 | Power-up pause and priming refreshes are complete |
| ref_req | output | 1 | Refresh or self-refresh wanted (valid side of the handshake) |
| ref_urgent | output | 1 | Owed count at its limit; preempt the open page |
| bus_own | output | 1 | Block currently drives the strobes |
| sr_active | output | 1 | Device is being held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high in every refresh |

## Verification
Several properties are checked on every cycle:
- CAS is low whenever RAS is low, and RAS never falls unless CAS was already low.
- No strobe is active while the block does not own them.
- A pending request is never withdrawn without a grant.
- `ready` never rises before the priming count of RAS falls.
- Every RAS pulse lasts either the normal width or at least the self-refresh minimum.

The bench scenarios show the cycle-exact quantities:
- the instant `ready` rises;
- the first request after one interval and the urgent flag after eight;
- saturation, shown by counting the refreshes in a drain;
- the lengths of the CAS lead and both precharge gaps;
- the self-refresh hold for a long and a short request;
- the absence of owed refreshes after a self-refresh that lasted longer than one interval.

// File: rtl/dram_rfr_pkg.sv
package dram_rfr_pkg;

  typedef enum logic [1:0] {
    CY_IDLE,
    CY_CSR,
    CY_RAS,
    CY_PRE
  } cyc_st_e;

  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_PRIME,
    PH_RUN,
    PH_SR_PRE,
    PH_SR_HOLD,
    PH_SR_POST
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfr_tick.sv
module rfr_tick #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  generate
    if (LEN <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_cnt
      localparam int CW = $clog2(LEN);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= CW'(LEN - 1);
        end else if (en) begin
          if (cnt == '0) cnt <= CW'(LEN - 1);
          else           cnt <= cnt - 1'b1;
        end
      end

      assign tick = en && (cnt == '0);
    end
  endgenerate

endmodule

// File: rtl/rfr_owed.sv
module rfr_owed #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pending,
  output logic full
);

  localparam int CW = $clog2(MAX + 1);

  logic [CW-1:0] count;
  logic          dec_eff;
  logic          inc_eff;

  assign full    = (count == CW'(MAX));
  assign pending = (count != '0);
  assign dec_eff = dec && pending;
  // at the limit a tick is only kept when a refresh frees a slot
  assign inc_eff = inc && (!full || dec_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case ({inc_eff, dec_eff})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rfr_cbr_engine.sv
module rfr_cbr_engine
  import dram_rfr_pkg::*;
#(
  parameter int T_CSR      = 1,
  parameter int T_RAS      = 5,
  parameter int T_RP       = 3,
  parameter int T_RPS      = 11,
  parameter int SR_MIN_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_req,
  input  logic release_i,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done
);

  localparam int MAXL = max2(max2(T_CSR, T_RAS), max2(max2(T_RP, T_RPS), SR_MIN_CYC));
  localparam int CW   = $clog2(MAXL + 1);

  cyc_st_e       st;
  logic [CW-1:0] cnt;
  logic          long_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= CY_IDLE;
      cnt    <= '0;
      long_q <= 1'b0;
    end else begin
      case (st)
        CY_IDLE: begin
          if (start) begin
            st     <= CY_CSR;
            cnt    <= CW'(T_CSR - 1);
            long_q <= long_req;
          end
        end
        CY_CSR: begin
          if (cnt == '0) begin
            st  <= CY_RAS;
            cnt <= long_q ? CW'(SR_MIN_CYC - 1) : CW'(T_RAS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CY_RAS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!long_q || release_i) begin
            st  <= CY_PRE;
            cnt <= long_q ? CW'(T_RPS - 1) : CW'(T_RP - 1);
          end
        end
        CY_PRE: begin
          if (cnt == '0) st <= CY_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= CY_IDLE;
      endcase
    end
  end

  assign idle  = (st == CY_IDLE);
  assign done  = (st == CY_PRE) && (cnt == '0);
  assign ras_n = (st != CY_RAS);
  assign cas_n = !((st == CY_CSR) || (st == CY_RAS));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfr_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 1560,
  parameter int PRIME_CNT    = 8,
  parameter int OWED_MAX     = 8,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 3,
  parameter int T_RPS        = 11,
  parameter int SR_MIN_CYC   = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic sr_req,
  output logic ready,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);

  localparam int PW = $clog2(PRIME_CNT + 1);

  phase_e        phase_q;
  logic [PW-1:0] prime_left;
  logic          busy_q;

  logic pause_tick, int_tick;
  logic eng_idle, eng_done, eng_start, eng_long;
  logic owed_pend, owed_full, owed_dec;
  logic in_run, accept;

  assign in_run = (phase_q == PH_RUN);

  rfr_tick #(.LEN(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (phase_q == PH_PAUSE),
    .tick (pause_tick)
  );

  rfr_tick #(.LEN(INTERVAL_CYC)) u_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_run),
    .tick (int_tick)
  );

  assign owed_dec = eng_done && (in_run || (phase_q == PH_SR_PRE) || (phase_q == PH_SR_POST));

  rfr_owed #(.MAX(OWED_MAX)) u_owed (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (int_tick),
    .dec    (owed_dec),
    .pending(owed_pend),
    .full   (owed_full)
  );

  assign ref_req  = in_run && !busy_q && (owed_pend || sr_req);
  assign accept   = ref_req && ref_gnt;
  assign eng_long = (phase_q == PH_SR_HOLD);
  // the engine is idle only in the first cycle of SR_HOLD and SR_POST
  assign eng_start = ((phase_q == PH_PRIME) && eng_idle && (prime_left != '0))
                   || accept
                   || (((phase_q == PH_SR_HOLD) || (phase_q == PH_SR_POST)) && eng_idle);

  rfr_cbr_engine #(
    .T_CSR     (T_CSR),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP),
    .T_RPS     (T_RPS),
    .SR_MIN_CYC(SR_MIN_CYC)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .long_req (eng_long),
    .release_i(!sr_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .idle     (eng_idle),
    .done     (eng_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_PAUSE;
      prime_left <= PW'(PRIME_CNT);
      busy_q     <= 1'b0;
    end else begin
      case (phase_q)
        PH_PAUSE: if (pause_tick) phase_q <= PH_PRIME;
        PH_PRIME: begin
          if (eng_done) begin
            prime_left <= prime_left - 1'b1;
            if (prime_left == PW'(1)) phase_q <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (accept) begin
            if (sr_req) phase_q <= PH_SR_PRE;
            else        busy_q  <= 1'b1;
          end else if (eng_done) begin
            busy_q <= 1'b0;
          end
        end
        PH_SR_PRE:  if (eng_done) phase_q <= PH_SR_HOLD;
        PH_SR_HOLD: if (eng_done) phase_q <= PH_SR_POST;
        PH_SR_POST: if (eng_done) phase_q <= PH_RUN;
        default:    phase_q <= PH_PAUSE;
      endcase
    end
  end

  assign ready      = (phase_q != PH_PAUSE) && (phase_q != PH_PRIME);
  assign bus_own    = !in_run || busy_q;
  assign sr_active  = (phase_q == PH_SR_HOLD);
  assign ref_urgent = owed_full;
  assign we_n       = 1'b1;

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int PRIME_CNT  = 8,
  parameter int T_RAS      = 5,
  parameter int SR_MIN_CYC = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic sr_req,
  input logic ready,
  input logic ref_req,
  input logic ref_urgent,
  input logic bus_own,
  input logic sr_active,
  input logic ras_n,
  input logic cas_n
);

  int fall_cnt;
  int low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fall_cnt <= 0;
      low_cnt  <= 0;
    end else begin
      if ($fell(ras_n) && fall_cnt < PRIME_CNT) fall_cnt <= fall_cnt + 1;
      if (ras_n)                        low_cnt <= 0;
      else if (low_cnt < SR_MIN_CYC)    low_cnt <= low_cnt + 1;
    end
  end

  // R3
  ras_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R3
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0));

  // R6
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !sr_req) |=> ref_req);

  // R2
  prime_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (fall_cnt >= PRIME_CNT));

  // R7
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && ready && !bus_own) |-> ref_req);

  // R8
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ((low_cnt == T_RAS) || (low_cnt >= SR_MIN_CYC)));

  // R10
  sr_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (bus_own && !ref_req));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .PRIME_CNT (PRIME_CNT),
  .T_RAS     (T_RAS),
  .SR_MIN_CYC(SR_MIN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_gnt   (ref_gnt),
  .sr_req    (sr_req),
  .ready     (ready),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .bus_own   (bus_own),
  .sr_active (sr_active),
  .ras_n     (ras_n),
  .cas_n     (cas_n)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;

  localparam int PAUSE  = 20;
  localparam int INTV   = 200;
  localparam int PRIME  = 8;
  localparam int OMAX   = 8;
  localparam int TCSR   = 2;
  localparam int TRAS   = 4;
  localparam int TRP    = 3;
  localparam int TRPS   = 6;
  localparam int SRMIN  = 10;
  localparam int CYCLEN = TCSR + TRAS + TRP + 1;

  logic clk = 1'b0;
  logic rst_n, ref_gnt, sr_req;
  logic ready, ref_req, ref_urgent, bus_own, sr_active, ras_n, cas_n, we_n;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .PRIME_CNT(PRIME), .OWED_MAX(OMAX),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_RPS(TRPS), .SR_MIN_CYC(SRMIN)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req),
    .ready(ready), .ref_req(ref_req), .ref_urgent(ref_urgent), .bus_own(bus_own),
    .sr_active(sr_active), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // strobe monitor, sampled mid-cycle
  int ready_cyc = 0, req_cyc = 0, urg_cyc = 0;
  bit ready_seen = 0, req_seen = 0, urg_seen = 0;
  int nfall = 0, long_cnt = 0, long_len = 0;
  int cas_fall_cyc = 0, cas_rise_cyc = 0, ras_fall_cyc = 0;
  bit have_rise = 0, prev_long = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int viol_r2 = 0, viol_r3 = 0, viol_r6 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ready && !ready_seen) begin ready_seen = 1; ready_cyc = cyc; end
      if (ref_req && !req_seen) begin req_seen = 1; req_cyc = cyc; end
      if (ref_urgent && !urg_seen) begin urg_seen = 1; urg_cyc = cyc; end
      if (!ready && ref_req) viol_r2++;
      if (!we_n) viol_r3++;
      if (!bus_own && (!ras_n || !cas_n)) viol_r6++;
      if (prev_cas && !cas_n) begin
        if (have_rise && (cyc - cas_rise_cyc) <= TRPS + 3) begin
          if (prev_long) chk("R9 exit precharge gap", cyc - cas_rise_cyc, TRPS + 1);
          else           chk("R4 precharge gap", cyc - cas_rise_cyc, TRP + 1);
        end
        cas_fall_cyc = cyc;
      end
      if (!prev_cas && cas_n) begin cas_rise_cyc = cyc; have_rise = 1; end
      if (prev_ras && !ras_n) begin
        chk("R3 cas lead", cyc - cas_fall_cyc, TCSR);
        nfall++;
        ras_fall_cyc = cyc;
      end
      if (!prev_ras && ras_n) begin
        chk("R3 cas rises with ras", int'(cas_n), 1);
        if (!sr_active) begin
          chk("R3 ras width", cyc - ras_fall_cyc, TRAS);
          prev_long = 0;
        end else begin
          long_len = cyc - ras_fall_cyc;
          long_cnt++;
          prev_long = 1;
        end
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base, lbase;
    rst_n = 1'b0; ref_gnt = 1'b0; sr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({ready, ref_req, ras_n, cas_n}), 4'b0011);
    rst_n = 1'b1;

    while (!ready) step(1);
    step(1);
    chk("R1 ready time", ready_cyc, PAUSE + PRIME * CYCLEN);
    chk("R2 priming count", nfall, PRIME);

    while (!ref_req) step(1);
    step(1);
    chk("R5 first request", req_cyc - ready_cyc, INTV);

    while (cyc < ready_cyc + 10 * INTV + 5) step(1);
    chk("R7 urgent time", urg_cyc - ready_cyc, OMAX * INTV);
    chk("R6 no refresh without grant", nfall, PRIME);
    chk("R6 request held, bus free", int'({ref_req, bus_own}), 2'b10);

    base = nfall;
    ref_gnt = 1'b1;
    step(1);
    while (ref_req || bus_own) step(1);
    step(1);
    chk("R7 saturated drain count", nfall - base, OMAX);
    chk("R7 urgent cleared", int'(ref_urgent), 0);

    base = nfall;
    while (cyc < ready_cyc + 14 * INTV + 20) step(1);
    chk("R5 one refresh per interval", nfall - base, 4);

    // long self-refresh hold
    base = nfall; lbase = long_cnt;
    sr_req = 1'b1;
    while (!(sr_active && !ras_n)) step(1);
    step(299);
    chk("R10 sr_active while held", int'(sr_active), 1);
    chk("R8 one refresh before entry", nfall - base, 2);
    sr_req = 1'b0;
    while (bus_own) step(1);
    step(1);
    chk("R9 refresh after exit", nfall - base, 3);
    chk("R8 long hold length", long_len, 300);
    chk("R9 single self-refresh", long_cnt - lbase, 1);
    chk("R9 nothing owed after exit", int'({ref_req, sr_active}), 0);

    // self-refresh request waits for the grant, then short hold
    ref_gnt = 1'b0;
    base = nfall;
    sr_req = 1'b1;
    step(30);
    chk("R6 self-refresh waits for grant", int'({ref_req, bus_own}), 2'b10);
    chk("R6 no strobes before grant", nfall - base, 0);
    ref_gnt = 1'b1;
    while (!(sr_active && !ras_n)) step(1);
    sr_req = 1'b0;
    while (bus_own) step(1);
    step(1);
    chk("R8 minimum hold length", long_len, SRMIN);
    chk("R10 sr_active cleared", int'(sr_active), 0);

    step(5);
    chk("R2 no request before ready", viol_r2, 0);
    chk("R3 write strobe high", viol_r3, 0);
    chk("R6 strobes idle when not owned", viol_r6, 0);

    summary();
    $finish;
  end

endmodule